// File: doc/BRIEF.md
# Scanline-Driven Register Update Engine

This block rewrites display registers between scanlines. For each channel switched on in an enable mask, it walks a list held in system memory once per horizontal blank. Each list entry holds a line count and either the data itself (direct mode) or a 16-bit pointer to the data (indirect mode). During each blank the block emits a short burst of byte-move descriptors that pair an A-side source address with a register address on the B side. A separate byte mover carries out the moves. When the block reads a count byte of zero, the channel switches itself off for the rest of the frame.

Software sets up eight channels through a byte-wide register port, using the same per-channel layout as the general DMA engine. It then writes the enable mask. The next line-start strobe loads every enabled channel's list pointer from its source address and clears its line counter. After that, every hblank strobe starts one service pass over the channels, from channel 0 up to the last, and `busy` stays high until the pass is over. List bytes come in through a valid/ready request port with an in-order response. A request stays valid with a stable address until it is accepted, and exactly one response pulse follows each accepted request, no earlier than the next cycle. Move descriptors leave on a valid/ready port. The receiver may hold `xfer_ready` low for any number of cycles, and the descriptor stays unchanged until it is taken.

Top module: `hdma_engine`

## Requirements
- R1: After reset, `busy`, `en_mask`, `mem_req_valid` and `xfer_valid` are 0 and every channel register reads back 0.
- R2: Each channel's registers can be written and read back at these offsets:
  - 0: control byte (bits 2:0 pattern, bit 6 indirect, bit 7 direction).
  - 1: destination byte.
  - 2 and 3: source address, low byte then high byte.
  - 4: list bank.
  - 5 and 6: indirect pointer, low byte then high byte.
  - 7: indirect bank.
  - 8 and 9: list pointer, low byte then high byte.
  - 0xA: line counter.
  - Any other offset reads 0.
- R3: Writing the enable mask arms an initialisation. The next `line_start` pulse then copies the source address into the list pointer and clears the line counter, for enabled channels only. Disabled channels keep their values. Mask bits are set only by a mask write.
- R4: An hblank pulse with any channel enabled raises `busy` in the next cycle. `busy` stays high until every enabled channel has been serviced, and channels are serviced in ascending index order.
- R5: When a serviced channel's line counter has bits 6:0 equal to zero, the block reads one byte at {list bank, list pointer} into the line counter and advances the pointer by one.
- R6: A fetched count byte of zero does the following:
  - clears that channel's mask bit;
  - zeroes its line counter;
  - leaves the list pointer on the zero byte;
  - emits no transfer, and the channel stays idle on later lines.
- R7: In indirect mode, two more bytes follow the count byte: first the low byte, then the high byte of the indirect pointer. The list pointer advances past both.
- R8: The line counter drops by one on every serviced line. Bit 7 of the decremented value is the repeat flag.
- R9: For the byte at index k, the A address is {indirect bank, indirect pointer + k} in indirect mode, or {list bank, list pointer + k} in direct mode. The 16-bit sum wraps inside the bank. The B address is 0x2100 + destination + register offset.
- R10: Each pattern sets the number of bytes per line and the register offset of each byte:
  - pattern 0: one byte, offset 0;
  - pattern 1: two bytes, offsets 0,1;
  - patterns 2 and 6: two bytes, offsets 0,0;
  - patterns 3 and 7: four bytes, offsets 0,0,1,1;
  - pattern 4: four bytes, offsets 0,1,2,3;
  - pattern 5: four bytes, offsets 0,1,0,1.
- R11: After a line's last byte:
  - with the repeat flag set, the data pointer in use (indirect or list) is advanced by the line's byte count;
  - in direct mode with the flag clear, the list pointer is advanced by that count only when counter bits 6:0 have reached zero;
  - otherwise the pointer is unchanged.
- R12: `xfer_to_a` on every descriptor equals control bit 7 of the channel that issued it.
- R13: `mem_req_valid` with its address, and `xfer_valid` with its addresses, stay asserted and stable until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Channel register write strobe |
| reg_ch | input | 3 | Channel index for register write and read |
| reg_off | input | 4 | Register offset within the channel |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational readback of the addressed register |
| en_wr | input | 1 | Enable mask write strobe |
| en_data | input | 8 | New enable mask |
| en_mask | output | 8 | Current enable mask |
| line_start | input | 1 | Start-of-line pulse that applies a pending initialisation |
| hblank | input | 1 | Horizontal blank pulse that starts a service pass |
| busy | output | 1 | Service pass in progress |
| mem_req_valid | output | 1 | List byte read request |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_addr | output | 24 | Bank and address of the list byte |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Read data |
| xfer_valid | output | 1 | Byte-move descriptor valid |
| xfer_ready | input | 1 | Descriptor accepted |
| xfer_a_addr | output | 24 | A-side address of the move |
| xfer_b_addr | output | 16 | B-side register address of the move |
| xfer_to_a | output | 1 | Move direction: 1 means B side to A side |

## Verification
Register readback is combinational, so it is sampled 1 ns after the address is set. An initialisation shows up at readback one edge after the `line_start` pulse. `busy` must be high at the first falling edge after the edge that sees the hblank pulse. The number of descriptors in a pass depends on stall patterns that the bench puts on both ready inputs. The bench therefore records every accepted descriptor and waits for `busy` to fall before comparing them. A clear of the mask bit is due one edge after the zero response. The bench checks the mask and the pointers only once the pass is over.

// File: rtl/hdma_pkg.sv
package hdma_pkg;
  localparam int PTRW  = 16;
  localparam int BANKW = 8;
  localparam int AW    = PTRW + BANKW;
  localparam logic [15:0] B_BASE = 16'h2100;
  localparam int BIT_IND = 6;
  localparam int BIT_DIR = 7;

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_FREQ, S_FWAIT, S_XFER} state_t;

  typedef struct packed {
    logic [7:0]      ctrl;
    logic [7:0]      dest;
    logic [PTRW-1:0] src;
    logic [7:0]      bank;
    logic [PTRW-1:0] ind;
    logic [7:0]      ibank;
    logic [PTRW-1:0] tptr;
    logic [7:0]      lc;
  } chan_t;
endpackage

// File: rtl/hdma_pattern.sv
module hdma_pattern (
  input  logic [2:0] mode,
  input  logic [1:0] idx,
  output logic [2:0] nbytes,
  output logic [1:0] boff
);
  always_comb begin
    nbytes = 3'd4;
    boff   = 2'd0;
    case (mode)
      3'd0:      begin nbytes = 3'd1; boff = 2'd0; end
      3'd1:      begin nbytes = 3'd2; boff = idx; end
      3'd2, 3'd6: begin nbytes = 3'd2; boff = 2'd0; end
      3'd3, 3'd7: begin nbytes = 3'd4; boff = {1'b0, idx[1]}; end
      3'd4:      begin nbytes = 3'd4; boff = idx; end
      default:   begin nbytes = 3'd4; boff = {1'b0, idx[0]}; end
    endcase
  end
endmodule

// File: rtl/hdma_regfile.sv
module hdma_regfile
  import hdma_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_we,
  input  logic [CW-1:0]   cpu_ch,
  input  logic [3:0]      cpu_off,
  input  logic [7:0]      cpu_wdata,
  output logic [7:0]      cpu_rdata,
  input  logic [NCH-1:0]  init,
  input  logic [CW-1:0]   eng_ch,
  input  logic            eng_tptr_we,
  input  logic [PTRW-1:0] eng_tptr,
  input  logic            eng_lc_we,
  input  logic [7:0]      eng_lc,
  input  logic            eng_ind_we,
  input  logic [PTRW-1:0] eng_ind,
  output chan_t           cur
);
  chan_t regs [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_t r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= '0;
      end else begin
        if (cpu_we && cpu_ch == CW'(c)) begin
          case (cpu_off)
            4'h0: r.ctrl       <= cpu_wdata;
            4'h1: r.dest       <= cpu_wdata;
            4'h2: r.src[7:0]   <= cpu_wdata;
            4'h3: r.src[15:8]  <= cpu_wdata;
            4'h4: r.bank       <= cpu_wdata;
            4'h5: r.ind[7:0]   <= cpu_wdata;
            4'h6: r.ind[15:8]  <= cpu_wdata;
            4'h7: r.ibank      <= cpu_wdata;
            4'h8: r.tptr[7:0]  <= cpu_wdata;
            4'h9: r.tptr[15:8] <= cpu_wdata;
            4'hA: r.lc         <= cpu_wdata;
            default: ;
          endcase
        end
        if (init[c]) begin
          r.tptr <= r.src;
          r.lc   <= '0;
        end
        if (eng_ch == CW'(c)) begin
          if (eng_tptr_we) r.tptr <= eng_tptr;
          if (eng_lc_we)   r.lc   <= eng_lc;
          if (eng_ind_we)  r.ind  <= eng_ind;
        end
      end
    end
    assign regs[c] = r;
  end

  chan_t sel;
  assign sel = regs[cpu_ch];
  assign cur = regs[eng_ch];

  always_comb begin
    case (cpu_off)
      4'h0: cpu_rdata = sel.ctrl;
      4'h1: cpu_rdata = sel.dest;
      4'h2: cpu_rdata = sel.src[7:0];
      4'h3: cpu_rdata = sel.src[15:8];
      4'h4: cpu_rdata = sel.bank;
      4'h5: cpu_rdata = sel.ind[7:0];
      4'h6: cpu_rdata = sel.ind[15:8];
      4'h7: cpu_rdata = sel.ibank;
      4'h8: cpu_rdata = sel.tptr[7:0];
      4'h9: cpu_rdata = sel.tptr[15:8];
      4'hA: cpu_rdata = sel.lc;
      default: cpu_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/hdma_engine.sv
module hdma_engine
  import hdma_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [CW-1:0]  reg_ch,
  input  logic [3:0]     reg_off,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  input  logic           en_wr,
  input  logic [NCH-1:0] en_data,
  output logic [NCH-1:0] en_mask,
  input  logic           line_start,
  input  logic           hblank,
  output logic           busy,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic [AW-1:0]  mem_req_addr,
  input  logic           mem_rsp_valid,
  input  logic [7:0]     mem_rsp_data,
  output logic           xfer_valid,
  input  logic           xfer_ready,
  output logic [AW-1:0]  xfer_a_addr,
  output logic [15:0]    xfer_b_addr,
  output logic           xfer_to_a
);
  state_t          state;
  logic [CW-1:0]   ch;
  logic [1:0]      phase;
  logic [1:0]      xidx;
  logic            pend_init;
  logic [NCH-1:0]  init_vec;
  chan_t           cur;
  logic [2:0]      nbytes;
  logic [1:0]      boff;
  logic            ind_mode, rep, last, kill, ch_last;
  logic [PTRW-1:0] p, p_next;
  logic            t_we, l_we, i_we;
  logic [PTRW-1:0] t_val, i_val;
  logic [7:0]      l_val;

  assign init_vec = (line_start && pend_init) ? en_mask : '0;

  hdma_regfile #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cpu_we(reg_we), .cpu_ch(reg_ch), .cpu_off(reg_off),
    .cpu_wdata(reg_wdata), .cpu_rdata(reg_rdata),
    .init(init_vec), .eng_ch(ch),
    .eng_tptr_we(t_we), .eng_tptr(t_val),
    .eng_lc_we(l_we), .eng_lc(l_val),
    .eng_ind_we(i_we), .eng_ind(i_val),
    .cur(cur)
  );

  hdma_pattern u_pat (
    .mode(cur.ctrl[2:0]), .idx(xidx), .nbytes(nbytes), .boff(boff)
  );

  assign ind_mode = cur.ctrl[BIT_IND];
  assign rep      = cur.lc[7];
  assign p        = ind_mode ? cur.ind : cur.tptr;
  assign p_next   = p + PTRW'(nbytes);
  assign last     = (3'(xidx) + 3'd1) == nbytes;
  assign ch_last  = ch == CW'(NCH - 1);
  assign kill     = state == S_FWAIT && mem_rsp_valid && phase == 2'd0 && mem_rsp_data == 8'h00;

  assign busy          = state != S_IDLE;
  assign mem_req_valid = state == S_FREQ;
  assign mem_req_addr  = {cur.bank, cur.tptr};
  assign xfer_valid    = state == S_XFER;
  assign xfer_a_addr   = {ind_mode ? cur.ibank : cur.bank, p + PTRW'(xidx)};
  assign xfer_b_addr   = B_BASE + 16'(cur.dest) + 16'(boff);
  assign xfer_to_a     = cur.ctrl[BIT_DIR];

  always_comb begin
    t_we = 1'b0; l_we = 1'b0; i_we = 1'b0;
    t_val = cur.tptr + 16'd1; l_val = cur.lc - 8'd1; i_val = cur.ind;
    case (state)
      S_SCAN: l_we = en_mask[ch] && cur.lc[6:0] != 7'd0;
      S_FWAIT: if (mem_rsp_valid) begin
        case (phase)
          2'd0: begin
            l_we  = 1'b1;
            l_val = (mem_rsp_data == 8'h00 || ind_mode) ? mem_rsp_data : mem_rsp_data - 8'd1;
            t_we  = mem_rsp_data != 8'h00;
          end
          2'd1: begin
            t_we = 1'b1; i_we = 1'b1; i_val = {cur.ind[15:8], mem_rsp_data};
          end
          default: begin
            t_we = 1'b1; i_we = 1'b1; i_val = {mem_rsp_data, cur.ind[7:0]};
            l_we = 1'b1;
          end
        endcase
      end
      S_XFER: if (xfer_ready && last) begin
        t_val = p_next; i_val = p_next;
        if (rep) begin
          i_we = ind_mode;
          t_we = !ind_mode;
        end else begin
          t_we = !ind_mode && cur.lc[6:0] == 7'd0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_mask   <= '0;
      pend_init <= 1'b0;
    end else if (en_wr) begin
      en_mask   <= en_data;
      pend_init <= |en_data;
    end else begin
      if (kill) en_mask[ch] <= 1'b0;
      if (line_start) pend_init <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ch    <= '0;
      phase <= '0;
      xidx  <= '0;
    end else begin
      case (state)
        S_IDLE: if (hblank && |en_mask) begin
          ch    <= '0;
          state <= S_SCAN;
        end
        S_SCAN: begin
          if (!en_mask[ch]) begin
            if (ch_last) state <= S_IDLE;
            else begin ch <= ch + 1'b1; state <= S_SCAN; end
          end else if (cur.lc[6:0] == 7'd0) begin
            phase <= 2'd0;
            state <= S_FREQ;
          end else begin
            xidx  <= '0;
            state <= S_XFER;
          end
        end
        S_FREQ: if (mem_req_ready) state <= S_FWAIT;
        S_FWAIT: if (mem_rsp_valid) begin
          if (kill) begin
            if (ch_last) state <= S_IDLE;
            else begin ch <= ch + 1'b1; state <= S_SCAN; end
          end else if (phase == 2'd0 && ind_mode) begin
            phase <= 2'd1; state <= S_FREQ;
          end else if (phase == 2'd1) begin
            phase <= 2'd2; state <= S_FREQ;
          end else begin
            xidx <= '0; state <= S_XFER;
          end
        end
        S_XFER: if (xfer_ready) begin
          if (!last) xidx <= xidx + 1'b1;
          else if (ch_last) state <= S_IDLE;
          else begin ch <= ch + 1'b1; state <= S_SCAN; end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_xfer_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_a_addr) && $stable(xfer_b_addr));
  assert_memreq_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  assert_busy_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(hblank));
  assert_mask_set_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_mask & ~$past(en_mask)) != '0 |-> $past(en_wr));
  assert_xfer_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> en_mask[ch]);
endmodule

// File: tb/hdma_engine_bench.sv
module hdma_engine_bench;
  localparam int CLK_NS = 10;
  localparam int WDOG = 150000;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [2:0] reg_ch = 0; logic [3:0] reg_off = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic en_wr = 0; logic [7:0] en_data = 0, en_mask;
  logic line_start = 0, hblank = 0, busy;
  logic mem_req_valid, mem_req_ready = 0; logic [23:0] mem_req_addr;
  logic mem_rsp_valid = 0; logic [7:0] mem_rsp_data = 0;
  logic xfer_valid, xfer_ready = 0; logic [23:0] xfer_a_addr;
  logic [15:0] xfer_b_addr; logic xfer_to_a;

  hdma_engine u_hdma_engine (.*);

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, rdy_ctr = 0;
  bit done = 0;
  logic [7:0] tmem [0:4095];
  logic [23:0] got_a [0:2047]; logic [15:0] got_b [0:2047]; logic got_d [0:2047];
  int got_n = 0;
  logic [23:0] exp_a [0:63]; logic [15:0] exp_b [0:63]; logic exp_d [0:63];
  int exp_n;
  logic [7:0] cfg_ctrl [8], cfg_dest [8], cfg_bank [8], cfg_ibank [8], m_lc [8];
  logic [15:0] cfg_src [8], m_tptr [8], m_ind [8];
  logic [7:0] m_en = 0;

  always @(negedge clk) begin
    rdy_ctr++;
    xfer_ready    = (rdy_ctr % 3) != 1;
    mem_req_ready = (rdy_ctr % 4) != 2;
  end

  always @(posedge clk) begin
    mem_rsp_valid <= rst_n && mem_req_valid && mem_req_ready;
    mem_rsp_data  <= tmem[mem_req_addr[11:0]];
    if (rst_n && xfer_valid && xfer_ready) begin
      got_a[got_n] <= xfer_a_addr; got_b[got_n] <= xfer_b_addr;
      got_d[got_n] <= xfer_to_a; got_n <= got_n + 1;
    end
    cyc++;
    if (cyc > WDOG && !done) begin
      done = 1; n_bad++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below %0d", cyc, WDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic int pat_len(logic [2:0] pt);
    if (pt == 0) return 1;
    if (pt == 1 || pt == 2 || pt == 6) return 2;
    return 4;
  endfunction

  function automatic int pat_off(logic [2:0] pt, int k);
    case (pt)
      3'd1, 3'd4: return k;
      3'd3, 3'd7: return k / 2;
      3'd5:       return k % 2;
      default:    return 0;
    endcase
  endfunction

  task automatic wr(int c, int off, logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_ch = 3'(c); reg_off = 4'(off); reg_wdata = d;
    @(negedge clk); reg_we = 0;
    case (off)
      0: cfg_ctrl[c] = d;  1: cfg_dest[c] = d;
      2: cfg_src[c][7:0] = d; 3: cfg_src[c][15:8] = d;
      4: cfg_bank[c] = d; 5: m_ind[c][7:0] = d; 6: m_ind[c][15:8] = d;
      7: cfg_ibank[c] = d; 8: m_tptr[c][7:0] = d; 9: m_tptr[c][15:8] = d;
      10: m_lc[c] = d; default: ;
    endcase
  endtask

  task automatic rd(int c, int off, output logic [7:0] d);
    @(negedge clk); reg_ch = 3'(c); reg_off = 4'(off); #1 d = reg_rdata;
  endtask

  task automatic rd16(int c, int off, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(c, off, lo); rd(c, off + 1, hi); d = {hi, lo};
  endtask

  task automatic frame(logic [7:0] mask);
    @(negedge clk); en_wr = 1; en_data = mask;
    @(negedge clk); en_wr = 0; line_start = 1;
    @(negedge clk); line_start = 0;
    m_en = mask;
    for (int c = 0; c < 8; c++) if (mask[c]) begin m_tptr[c] = cfg_src[c]; m_lc[c] = 0; end
  endtask

  task automatic model_line();
    exp_n = 0;
    for (int c = 0; c < 8; c++) if (m_en[c]) begin
      logic ind; logic skip; logic [7:0] cnt; logic [15:0] p; int n;
      ind = cfg_ctrl[c][6]; skip = 0;
      if (m_lc[c][6:0] == 0) begin
        cnt = tmem[m_tptr[c][11:0]];
        m_lc[c] = cnt;
        if (cnt == 0) begin m_en[c] = 0; skip = 1; end
        else begin
          m_tptr[c]++;
          if (ind) begin
            m_ind[c] = {tmem[m_tptr[c][11:0] + 12'd1], tmem[m_tptr[c][11:0]]};
            m_tptr[c] += 2;
          end
        end
      end
      if (!skip) begin
        m_lc[c]--;
        p = ind ? m_ind[c] : m_tptr[c];
        n = pat_len(cfg_ctrl[c][2:0]);
        for (int k = 0; k < n; k++) begin
          exp_a[exp_n] = {ind ? cfg_ibank[c] : cfg_bank[c], p + 16'(k)};
          exp_b[exp_n] = 16'h2100 + 16'(cfg_dest[c]) + 16'(pat_off(cfg_ctrl[c][2:0], k));
          exp_d[exp_n] = cfg_ctrl[c][7];
          exp_n++;
        end
        if (m_lc[c][7]) begin
          if (ind) m_ind[c] = p + 16'(n); else m_tptr[c] = p + 16'(n);
        end else if (!ind && m_lc[c][6:0] == 0) m_tptr[c] = p + 16'(n);
      end
    end
  endtask

  task automatic run_line();
    int base; bit any;
    any = |m_en;
    model_line();
    base = got_n;
    @(negedge clk); hblank = 1;
    @(negedge clk); hblank = 0;
    check(busy == any, "R4", "busy one cycle after hblank", busy, any);
    while (busy) @(negedge clk);
    @(negedge clk);
    check(got_n - base == exp_n, "R10", "descriptor count", got_n - base, exp_n);
    for (int i = 0; i < exp_n && base + i < got_n; i++) begin
      check(got_a[base+i] == exp_a[i], "R9", "A address", got_a[base+i], exp_a[i]);
      check(got_b[base+i] == exp_b[i], "R10", "B address", got_b[base+i], exp_b[i]);
      check(got_d[base+i] == exp_d[i], "R12", "direction", got_d[base+i], exp_d[i]);
    end
    check(en_mask == m_en, "R6", "enable mask", en_mask, m_en);
  endtask

  task automatic build_table(logic [15:0] t, bit ind, int n, logic [15:0] p1, logic [15:0] p2);
    int a; a = t;
    tmem[a] = 8'h02; a++;
    if (ind) begin tmem[a] = p1[7:0]; tmem[a+1] = p1[15:8]; a += 2; end
    else for (int k = 0; k < n; k++) begin tmem[a] = 8'(a); a++; end
    tmem[a] = 8'h82; a++;
    if (ind) begin tmem[a] = p2[7:0]; tmem[a+1] = p2[15:8]; a += 2; end
    else for (int k = 0; k < 2 * n; k++) begin tmem[a] = 8'(a); a++; end
    tmem[a] = 8'h00;
  endtask

  initial begin
    logic [7:0] v; logic [15:0] w;
    for (int i = 0; i < 4096; i++) tmem[i] = 8'h00;
    for (int c = 0; c < 8; c++) begin
      cfg_ctrl[c] = 0; cfg_dest[c] = 0; cfg_bank[c] = 0; cfg_ibank[c] = 0;
      cfg_src[c] = 0; m_tptr[c] = 0; m_ind[c] = 0; m_lc[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0, "R1", "busy after reset", busy, 0);
    check(en_mask == 0, "R1", "mask after reset", en_mask, 0);
    check(!xfer_valid && !mem_req_valid, "R1", "valids after reset", {xfer_valid, mem_req_valid}, 0);
    for (int off = 0; off < 16; off++) begin
      rd(3, off, v); check(v == 0, "R1", "register after reset", v, 0);
    end

    for (int c = 0; c < 8; c++)
      for (int off = 0; off < 11; off++) wr(c, off, 8'(c * 29 + off * 7 + 1));
    for (int c = 0; c < 8; c++)
      for (int off = 0; off < 16; off++) begin
        rd(c, off, v);
        check(v == (off < 11 ? 8'(c * 29 + off * 7 + 1) : 8'h00), "R2", "readback", v,
              off < 11 ? 8'(c * 29 + off * 7 + 1) : 8'h00);
      end

    for (int run = 0; run < 16; run++) begin
      int c, n, oc; bit ind; logic [15:0] t, p1, p2;
      c = run % 8; ind = run / 8; n = pat_len(3'(c)); oc = (c + 3) % 8;
      t = 16'h0100 + 16'(run * 64); p1 = 16'h8000 + 16'(run * 16); p2 = 16'hC000 + 16'(run * 16);
      wr(c, 0, {c[0], ind, 3'b000, 3'(c)});
      wr(c, 1, 8'h10 + 8'(run)); wr(c, 2, t[7:0]); wr(c, 3, t[15:8]);
      wr(c, 4, 8'h20 + 8'(run)); wr(c, 7, 8'h60 + 8'(run));
      build_table(t, ind, n, p1, p2);
      frame(8'(1 << c));
      rd16(c, 8, w); check(w == t, "R3", "pointer loaded on line start", w, t);
      rd(c, 10, v); check(v == 0, "R3", "counter cleared on line start", v, 0);
      rd16(oc, 8, w); check(w == m_tptr[oc], "R3", "disabled channel untouched", w, m_tptr[oc]);
      repeat (6) run_line();
      rd16(c, 8, w);
      check(w == (ind ? t + 16'd6 : t + 16'(3 * n + 2)), "R5", "pointer at zero entry (R6 R7 R11)", w,
            ind ? t + 16'd6 : t + 16'(3 * n + 2));
      rd(c, 10, v); check(v == 0, "R6", "counter after end", v, 0);
      if (ind) begin
        rd16(c, 5, w); check(w == p2 + 16'(2 * n), "R11", "indirect pointer after repeats", w, p2 + 16'(2 * n));
      end
      rd(c, 10, v); check(v == m_lc[c], "R8", "counter model", v, m_lc[c]);
    end

    wr(2, 0, 8'h01); wr(2, 1, 8'h05); wr(2, 2, 8'h00); wr(2, 3, 8'h0A); wr(2, 4, 8'h33);
    wr(5, 0, 8'hC3); wr(5, 1, 8'h40); wr(5, 2, 8'h40); wr(5, 3, 8'h0A); wr(5, 4, 8'h34); wr(5, 7, 8'h70);
    wr(7, 0, 8'h44); wr(7, 1, 8'hFE); wr(7, 2, 8'h80); wr(7, 3, 8'h0A); wr(7, 4, 8'h35); wr(7, 7, 8'h71);
    build_table(16'h0A00, 0, 2, 0, 0);
    build_table(16'h0A40, 1, 4, 16'h1230, 16'h5670);
    build_table(16'h0A80, 1, 4, 16'hFFFE, 16'hFFFD);
    frame(8'hA4);
    repeat (6) run_line();
    check(en_mask == 0, "R6", "all channels ended", en_mask, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule